// File: doc/BRIEF.md
# Scratch-Memory Destination-Chain DMA Sequencer

This block is the control engine for a DMA channel that empties a 16 KiB local scratch memory into system memory. Software builds a list in the scratch memory: each entry is a 128-bit control word followed by the payload quadwords it describes. The sequencer reads the control word at the current local address and takes from it a payload length, a type code, an interrupt flag and a destination address. It hands a data-phase request to an external mover and repeats with the next control word until the list terminates.

The channel is armed with a local address, a destination address, a pending quadword count and a flag that marks the previous control word as final. A pending count is drained before any control word is read. One type code can also record a stall address, which tells a consumer how far the written data reaches. On termination the channel drops its busy indication and pulses an interrupt.

Top module: `dchain_seq`

## Requirements
- R1: A `go_i` pulse while idle arms the channel: `busy_o` rises and, with a zero pending count, the first control word is requested at `init_laddr_i`. A `go_i` pulse while busy is ignored.
- R2: Each control word is read at the local address. The local address then advances by 16 and wraps within 14 bits, so 0x3FF0 is followed by 0x0000.
- R3: Control word fields are: length in bits 15:0, type in bits 30:28, interrupt flag in bit 31, destination in bits 63:32. A nonzero length issues one data-phase request with that destination, source equal to the advanced local address, and that length. A zero length issues no request.
- R4: After a data phase both the local address and the destination advance by length × 16. The local address wraps within 14 bits.
- R5: Type 1 (continue) moves its payload and then reads the next control word.
- R6: Type 7 (final) moves its payload and then terminates the list.
- R7: Type 0 (continue with stall) acts like type 1. When `stall_en_i` is high it also loads `stall_addr_o` with destination + length × 16. When `stall_en_i` is low, `stall_addr_o` keeps its value.
- R8: If `tie_i` and the control word's interrupt flag are both set, the list terminates after that word's payload. With `tie_i` low the flag has no effect.
- R9: A nonzero pending count at arming is moved first, from `init_laddr_i` to `init_dst_i`. If `init_end_i` was set the list ends after it with no control word read. Otherwise the next control word follows the pending payload.
- R10: Termination raises `irq_o` for exactly one cycle, with `busy_o` already low.
- R11: Any other type (2–6) terminates at once with no data phase and sets `err_o`. The next accepted `go_i` clears `err_o`.
- R12: A data-phase request holds its source, destination and length steady until `xfer_done_i`, and is never raised together with a control-word request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Arm the channel (pulse) |
| tie_i | input | 1 | Tag interrupt enable |
| stall_en_i | input | 1 | Stall control selects this channel |
| init_laddr_i | input | 14 | Starting local address |
| init_qwc_i | input | 16 | Pending quadword count at arming |
| init_dst_i | input | 32 | Destination for the pending data |
| init_end_i | input | 1 | Previous control word was final |
| tag_req_o | output | 1 | Control-word read request |
| tag_addr_o | output | 14 | Current local address |
| tag_vld_i | input | 1 | Control word returned |
| tag_data_i | input | 128 | Control word data |
| xfer_req_o | output | 1 | Data-phase request |
| xfer_src_o | output | 14 | Data-phase local source address |
| xfer_dst_o | output | 32 | Data-phase destination address |
| xfer_qwc_o | output | 16 | Data-phase quadword count |
| xfer_done_i | input | 1 | Data phase complete |
| stall_addr_o | output | 32 | Stall address register |
| busy_o | output | 1 | Channel running (start bit) |
| irq_o | output | 1 | Channel interrupt pulse |
| err_o | output | 1 | Undefined type seen |

## Verification
The stall-address load and the interrupt-driven termination both resolve during the decode of one control word. The bench provokes this with a continue-with-stall word whose interrupt flag is set while `tie_i` and `stall_en_i` are high. It then checks that the payload is still moved, that `stall_addr_o` equals destination plus length × 16, and that no further control word is requested before the one-cycle interrupt. A second run uses the same flag with both enables low and checks that the list continues and the stall address is left unchanged.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_TAG,
    ST_DECODE,
    ST_DATA,
    ST_CHECK_END,
    ST_DONE
  } dchain_state_e;

  localparam logic [2:0] ID_CNTS = 3'd0;
  localparam logic [2:0] ID_CNT  = 3'd1;
  localparam logic [2:0] ID_END  = 3'd7;

  localparam int QWC_LSB = 0;
  localparam int ID_LSB  = 28;
  localparam int IRQ_BIT = 31;
  localparam int DST_LSB = 32;

endpackage

// File: rtl/dchain_tag_dec.sv
module dchain_tag_dec
  import dchain_pkg::*;
#(
  parameter int TAG_W = 128,
  parameter int QWC_W = 16,
  parameter int DST_W = 32
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic [QWC_W-1:0] qwc_o,
  output logic [DST_W-1:0] dst_o,
  output logic             irq_o,
  output logic             valid_o,
  output logic             is_cnts_o,
  output logic             is_end_o
);
  logic [2:0] id;

  assign qwc_o = tag_i[QWC_LSB +: QWC_W];
  assign dst_o = tag_i[DST_LSB +: DST_W];
  assign irq_o = tag_i[IRQ_BIT];
  assign id    = tag_i[ID_LSB +: 3];

  always_comb begin
    valid_o   = 1'b0;
    is_cnts_o = 1'b0;
    is_end_o  = 1'b0;
    unique case (id)
      ID_CNTS: begin valid_o = 1'b1; is_cnts_o = 1'b1; end
      ID_CNT:  valid_o = 1'b1;
      ID_END:  begin valid_o = 1'b1; is_end_o = 1'b1; end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dchain_addr_unit.sv
module dchain_addr_unit #(
  parameter int LADDR_W = 14,
  parameter int QWC_W   = 16,
  parameter int DST_W   = 32,
  parameter int TAG_W   = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_init_i,
  input  logic [LADDR_W-1:0] init_laddr_i,
  input  logic [QWC_W-1:0]   init_qwc_i,
  input  logic [DST_W-1:0]   init_dst_i,
  input  logic               cap_tag_i,
  input  logic [TAG_W-1:0]   tag_data_i,
  input  logic               ld_tag_i,
  input  logic               ld_stall_i,
  input  logic [QWC_W-1:0]   dec_qwc_i,
  input  logic [DST_W-1:0]   dec_dst_i,
  input  logic               adv_i,
  output logic [TAG_W-1:0]   tag_o,
  output logic [LADDR_W-1:0] laddr_o,
  output logic [DST_W-1:0]   dst_o,
  output logic [QWC_W-1:0]   qwc_o,
  output logic [DST_W-1:0]   stall_o
);
  localparam int BYTES_W = QWC_W + 4;

  logic [LADDR_W-1:0] laddr_q;
  logic [DST_W-1:0]   dst_q, stall_q;
  logic [QWC_W-1:0]   qwc_q;
  logic [TAG_W-1:0]   tag_q;
  logic [BYTES_W-1:0] run_bytes, dec_bytes;

  assign run_bytes = {qwc_q, 4'b0};
  assign dec_bytes = {dec_qwc_i, 4'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      laddr_q <= '0;
      dst_q   <= '0;
      qwc_q   <= '0;
      tag_q   <= '0;
      stall_q <= '0;
    end else begin
      if (ld_init_i) begin
        laddr_q <= init_laddr_i;
        dst_q   <= init_dst_i;
        qwc_q   <= init_qwc_i;
      end else if (cap_tag_i) begin
        tag_q   <= tag_data_i;
        laddr_q <= laddr_q + LADDR_W'(16);
      end else if (ld_tag_i) begin
        dst_q <= dec_dst_i;
        qwc_q <= dec_qwc_i;
      end else if (adv_i) begin
        laddr_q <= laddr_q + LADDR_W'(run_bytes);
        dst_q   <= dst_q + DST_W'(run_bytes);
        qwc_q   <= '0;
      end
      if (ld_stall_i) stall_q <= dec_dst_i + DST_W'(dec_bytes);
    end
  end

  assign tag_o   = tag_q;
  assign laddr_o = laddr_q;
  assign dst_o   = dst_q;
  assign qwc_o   = qwc_q;
  assign stall_o = stall_q;
endmodule

// File: rtl/dchain_fsm.sv
module dchain_fsm
  import dchain_pkg::*;
#(
  parameter int QWC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             tie_i,
  input  logic             stall_en_i,
  input  logic [QWC_W-1:0] init_qwc_i,
  input  logic             init_end_i,
  input  logic             tag_vld_i,
  input  logic             xfer_done_i,
  input  logic [QWC_W-1:0] dec_qwc_i,
  input  logic             dec_irq_i,
  input  logic             dec_valid_i,
  input  logic             dec_cnts_i,
  input  logic             dec_end_i,
  output logic             ld_init_o,
  output logic             cap_tag_o,
  output logic             ld_tag_o,
  output logic             ld_stall_o,
  output logic             adv_o,
  output logic             tag_req_o,
  output logic             xfer_req_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic             err_o
);
  dchain_state_e state_q, state_d;
  logic term_q, term_d, err_q, err_d;

  always_comb begin
    state_d    = state_q;
    term_d     = term_q;
    err_d      = err_q;
    ld_init_o  = 1'b0;
    cap_tag_o  = 1'b0;
    ld_tag_o   = 1'b0;
    ld_stall_o = 1'b0;
    adv_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go_i) begin
        ld_init_o = 1'b1;
        err_d     = 1'b0;
        term_d    = init_end_i && (init_qwc_i != '0);
        state_d   = (init_qwc_i != '0) ? ST_DATA : ST_FETCH_TAG;
      end
      ST_FETCH_TAG: if (tag_vld_i) begin
        cap_tag_o = 1'b1;
        state_d   = ST_DECODE;
      end
      ST_DECODE: begin
        if (!dec_valid_i) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          ld_tag_o   = 1'b1;
          ld_stall_o = dec_cnts_i && stall_en_i;
          term_d     = dec_end_i || (dec_irq_i && tie_i);
          state_d    = (dec_qwc_i != '0) ? ST_DATA : ST_CHECK_END;
        end
      end
      ST_DATA: if (xfer_done_i) begin
        adv_o   = 1'b1;
        state_d = ST_CHECK_END;
      end
      ST_CHECK_END: state_d = term_q ? ST_DONE : ST_FETCH_TAG;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      term_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      term_q  <= term_d;
      err_q   <= err_d;
    end
  end

  assign tag_req_o  = (state_q == ST_FETCH_TAG);
  assign xfer_req_o = (state_q == ST_DATA);
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign irq_o      = (state_q == ST_DONE);
  assign err_o      = err_q;
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq #(
  parameter int LADDR_W = 14,
  parameter int QWC_W   = 16,
  parameter int DST_W   = 32,
  parameter int TAG_W   = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               tie_i,
  input  logic               stall_en_i,
  input  logic [LADDR_W-1:0] init_laddr_i,
  input  logic [QWC_W-1:0]   init_qwc_i,
  input  logic [DST_W-1:0]   init_dst_i,
  input  logic               init_end_i,
  output logic               tag_req_o,
  output logic [LADDR_W-1:0] tag_addr_o,
  input  logic               tag_vld_i,
  input  logic [TAG_W-1:0]   tag_data_i,
  output logic               xfer_req_o,
  output logic [LADDR_W-1:0] xfer_src_o,
  output logic [DST_W-1:0]   xfer_dst_o,
  output logic [QWC_W-1:0]   xfer_qwc_o,
  input  logic               xfer_done_i,
  output logic [DST_W-1:0]   stall_addr_o,
  output logic               busy_o,
  output logic               irq_o,
  output logic               err_o
);
  logic             ld_init, cap_tag, ld_tag, ld_stall, adv;
  logic [TAG_W-1:0] tag_q;
  logic [QWC_W-1:0] dec_qwc;
  logic [DST_W-1:0] dec_dst;
  logic             dec_irq, dec_valid, dec_cnts, dec_end;
  logic [LADDR_W-1:0] laddr;

  dchain_tag_dec #(.TAG_W(TAG_W), .QWC_W(QWC_W), .DST_W(DST_W)) u_dec (
    .tag_i(tag_q), .qwc_o(dec_qwc), .dst_o(dec_dst), .irq_o(dec_irq),
    .valid_o(dec_valid), .is_cnts_o(dec_cnts), .is_end_o(dec_end)
  );

  dchain_addr_unit #(.LADDR_W(LADDR_W), .QWC_W(QWC_W), .DST_W(DST_W), .TAG_W(TAG_W)) u_addr (
    .clk_i, .rst_ni,
    .ld_init_i(ld_init), .init_laddr_i, .init_qwc_i, .init_dst_i,
    .cap_tag_i(cap_tag), .tag_data_i,
    .ld_tag_i(ld_tag), .ld_stall_i(ld_stall),
    .dec_qwc_i(dec_qwc), .dec_dst_i(dec_dst), .adv_i(adv),
    .tag_o(tag_q), .laddr_o(laddr), .dst_o(xfer_dst_o), .qwc_o(xfer_qwc_o),
    .stall_o(stall_addr_o)
  );

  dchain_fsm #(.QWC_W(QWC_W)) u_fsm (
    .clk_i, .rst_ni, .go_i, .tie_i, .stall_en_i, .init_qwc_i, .init_end_i,
    .tag_vld_i, .xfer_done_i,
    .dec_qwc_i(dec_qwc), .dec_irq_i(dec_irq), .dec_valid_i(dec_valid),
    .dec_cnts_i(dec_cnts), .dec_end_i(dec_end),
    .ld_init_o(ld_init), .cap_tag_o(cap_tag), .ld_tag_o(ld_tag),
    .ld_stall_o(ld_stall), .adv_o(adv),
    .tag_req_o, .xfer_req_o, .busy_o, .irq_o, .err_o
  );

  assign tag_addr_o = laddr;
  assign xfer_src_o = laddr;
endmodule

// File: rtl/dchain_seq_chk.sv
module dchain_seq_chk #(
  parameter int LADDR_W = 14,
  parameter int QWC_W   = 16,
  parameter int DST_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tag_req_o,
  input logic [LADDR_W-1:0] tag_addr_o,
  input logic               tag_vld_i,
  input logic               xfer_req_o,
  input logic [LADDR_W-1:0] xfer_src_o,
  input logic [DST_W-1:0]   xfer_dst_o,
  input logic [QWC_W-1:0]   xfer_qwc_o,
  input logic               xfer_done_i,
  input logic               busy_o,
  input logic               irq_o,
  input logic               err_o
);
  logic [LADDR_W-1:0] nxt_src;
  assign nxt_src = xfer_src_o + LADDR_W'({xfer_qwc_o, 4'b0});

  p_req_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_req_o |-> busy_o);
  p_tag_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_req_o && tag_vld_i |=> tag_addr_o == $past(tag_addr_o) + LADDR_W'(16));
  p_src_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && xfer_done_i |=> tag_addr_o == $past(nxt_src));
  p_irq_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o);
  p_irq_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_err_term_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> irq_o);
  p_xfer_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> xfer_req_o && $stable(xfer_src_o)
      && $stable(xfer_dst_o) && $stable(xfer_qwc_o));
  p_req_mutex_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tag_req_o && xfer_req_o));
endmodule

bind dchain_seq dchain_seq_chk #(.LADDR_W(LADDR_W), .QWC_W(QWC_W), .DST_W(DST_W)) u_chk (
  .clk_i, .rst_ni, .tag_req_o, .tag_addr_o, .tag_vld_i, .xfer_req_o,
  .xfer_src_o, .xfer_dst_o, .xfer_qwc_o, .xfer_done_i, .busy_o, .irq_o, .err_o
);

// File: tb/dchain_seq_tb_top.sv
`timescale 1ns/1ps
module dchain_seq_tb_top;
  logic         clk_i = 0;
  logic         rst_ni = 0;
  logic         go_i = 0, tie_i = 0, stall_en_i = 0, init_end_i = 0;
  logic [13:0]  init_laddr_i = '0;
  logic [15:0]  init_qwc_i = '0;
  logic [31:0]  init_dst_i = '0;
  logic         tag_req_o, tag_vld_i = 0;
  logic [13:0]  tag_addr_o;
  logic [127:0] tag_data_i = '0;
  logic         xfer_req_o, xfer_done_i = 0;
  logic [13:0]  xfer_src_o;
  logic [31:0]  xfer_dst_o, stall_addr_o;
  logic [15:0]  xfer_qwc_o;
  logic         busy_o, irq_o, err_o;

  typedef struct packed {
    logic [31:0] dst;
    logic [13:0] src;
    logic [15:0] qwc;
  } xfer_t;

  xfer_t        exp_xq[$];
  logic [13:0]  exp_tq[$];
  logic [127:0] mem [1024];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk_i = ~clk_i;

  dchain_seq dut_i (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_tag(input logic [2:0] id, input logic irq,
                                          input logic [15:0] qwc, input logic [31:0] dst);
    return {64'h0, dst, irq, id, 12'h0, qwc};
  endfunction

  function automatic xfer_t mk_x(input logic [31:0] d, input logic [13:0] s, input logic [15:0] q);
    xfer_t x;
    x.dst = d; x.src = s; x.qwc = q;
    return x;
  endfunction

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // control-word responder: one cycle latency, checks requested address
  initial begin
    forever begin
      @(negedge clk_i);
      if (tag_req_o && !tag_vld_i) begin
        if (exp_tq.size() == 0) chk("R2 unexpected tag read", 32'(tag_addr_o), 32'hFFFF);
        else chk("R2 tag address", 32'(tag_addr_o), 32'(exp_tq.pop_front()));
        tag_data_i = mem[tag_addr_o[13:4]];
        tag_vld_i  = 1'b1;
      end else tag_vld_i = 1'b0;
    end
  end

  // data-phase monitor: scoreboard compare, done after three cycles
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk_i);
      if (xfer_done_i) xfer_done_i = 1'b0;
      else if (xfer_req_o) begin
        wcnt++;
        if (wcnt == 3) begin
          wcnt = 0;
          if (exp_xq.size() == 0) chk("R3 unexpected data phase", 32'(xfer_qwc_o), 32'hFFFF);
          else begin
            xfer_t e;
            e = exp_xq.pop_front();
            chk("R3 xfer dst", xfer_dst_o, e.dst);
            chk("R4 xfer src", 32'(xfer_src_o), 32'(e.src));
            chk("R3 xfer qwc", 32'(xfer_qwc_o), 32'(e.qwc));
          end
          xfer_done_i = 1'b1;
        end
      end
    end
  end

  task automatic run(input string r, input logic [13:0] la, input logic [15:0] q,
                     input logic [31:0] d, input logic e, input logic poke);
    @(negedge clk_i);
    init_laddr_i = la; init_qwc_i = q; init_dst_i = d; init_end_i = e;
    go_i = 1'b1;
    @(negedge clk_i);
    go_i = 1'b0;
    chk({r, " R1 busy after go"}, 32'(busy_o), 1);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      init_laddr_i = 14'h0AA0; init_qwc_i = 16'd9; init_dst_i = 32'hDEAD0000;
      go_i = 1'b1;
      @(negedge clk_i);
      go_i = 1'b0;
    end
    while (!irq_o) @(negedge clk_i);
    chk({r, " R10 busy low at irq"}, 32'(busy_o), 0);
    chk({r, " R6 data phases all seen"}, 32'(exp_xq.size()), 0);
    chk({r, " R5 tag reads all seen"}, 32'(exp_tq.size()), 0);
    @(negedge clk_i);
    chk({r, " R10 irq single cycle"}, 32'(irq_o), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[14'h100 >> 4]  = mk_tag(3'd1, 1'b0, 16'd2, 32'h1000);
    mem[14'h130 >> 4]  = mk_tag(3'd0, 1'b0, 16'd3, 32'h2000);
    mem[14'h170 >> 4]  = mk_tag(3'd7, 1'b0, 16'd1, 32'h3000);
    mem[14'h3FF0 >> 4] = mk_tag(3'd1, 1'b0, 16'd2, 32'h8000);
    mem[14'h020 >> 4]  = mk_tag(3'd7, 1'b0, 16'd0, 32'h0);
    mem[14'h200 >> 4]  = mk_tag(3'd0, 1'b1, 16'd4, 32'h5000);
    mem[14'h300 >> 4]  = mk_tag(3'd0, 1'b1, 16'd1, 32'h6000);
    mem[14'h320 >> 4]  = mk_tag(3'd7, 1'b0, 16'd0, 32'h0);
    mem[14'h420 >> 4]  = mk_tag(3'd7, 1'b0, 16'd1, 32'h7200);
    mem[14'h500 >> 4]  = mk_tag(3'd3, 1'b0, 16'd2, 32'h9000);

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 reset busy", 32'(busy_o), 0);
    chk("R10 reset irq", 32'(irq_o), 0);
    chk("R11 reset err", 32'(err_o), 0);
    chk("R12 reset requests", 32'({tag_req_o, xfer_req_o}), 0);
    chk("R7 reset stall", stall_addr_o, 0);

    // R5/R6/R7: continue, continue-with-stall, final
    stall_en_i = 1'b1; tie_i = 1'b0;
    exp_tq = '{14'h100, 14'h130, 14'h170};
    exp_xq = '{mk_x(32'h1000, 14'h110, 16'd2), mk_x(32'h2000, 14'h140, 16'd3),
               mk_x(32'h3000, 14'h180, 16'd1)};
    run("chain", 14'h100, 16'd0, 32'h0, 1'b0, 1'b0);
    chk("R7 stall address loaded", stall_addr_o, 32'h2030);

    // R2: local address wrap, zero-length final word
    exp_tq = '{14'h3FF0, 14'h0020};
    exp_xq = '{mk_x(32'h8000, 14'h0000, 16'd2)};
    run("wrap", 14'h3FF0, 16'd0, 32'h0, 1'b0, 1'b0);

    // R8 with R7 in the same decode
    tie_i = 1'b1;
    exp_tq = '{14'h200};
    exp_xq = '{mk_x(32'h5000, 14'h210, 16'd4)};
    run("irq+stall", 14'h200, 16'd0, 32'h0, 1'b0, 1'b0);
    chk("R7 stall on irq-terminated word", stall_addr_o, 32'h5040);

    // R8 flag ignored with tie low, R7 stall unchanged with stall_en low
    tie_i = 1'b0; stall_en_i = 1'b0;
    exp_tq = '{14'h300, 14'h320};
    exp_xq = '{mk_x(32'h6000, 14'h310, 16'd1)};
    run("noirq", 14'h300, 16'd0, 32'h0, 1'b0, 1'b0);
    chk("R7 stall kept when disabled", stall_addr_o, 32'h5040);

    // R9: pending data, final flag set
    exp_tq = '{};
    exp_xq = '{mk_x(32'h7000, 14'h400, 16'd5)};
    run("pend_end", 14'h400, 16'd5, 32'h7000, 1'b1, 1'b0);

    // R9: pending data then chain continues
    exp_tq = '{14'h420};
    exp_xq = '{mk_x(32'h7100, 14'h400, 16'd2), mk_x(32'h7200, 14'h430, 16'd1)};
    run("pend_cont", 14'h400, 16'd2, 32'h7100, 1'b0, 1'b0);

    // R11: undefined type
    exp_tq = '{14'h500};
    exp_xq = '{};
    run("bad_id", 14'h500, 16'd0, 32'h0, 1'b0, 1'b0);
    chk("R11 err set", 32'(err_o), 1);
    exp_xq = '{mk_x(32'h7000, 14'h400, 16'd5)};
    run("after_err", 14'h400, 16'd5, 32'h7000, 1'b1, 1'b0);
    chk("R11 err cleared by go", 32'(err_o), 0);

    // R1: go while busy ignored
    stall_en_i = 1'b1;
    exp_tq = '{14'h100, 14'h130, 14'h170};
    exp_xq = '{mk_x(32'h1000, 14'h110, 16'd2), mk_x(32'h2000, 14'h140, 16'd3),
               mk_x(32'h3000, 14'h180, 16'd1)};
    run("go_busy R1", 14'h100, 16'd0, 32'h0, 1'b0, 1'b1);
    repeat (4) @(negedge clk_i);
    chk("R1 stays idle after run", 32'(busy_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule